// File: doc/BRIEF.md
# Bit-Mask Decode and Priority Encode Unit

This combinational helper converts between small bit indices and bit masks for a 32-bit datapath. Three decode modes turn the low bits of an operand into a one-hot pattern. The 32-bit form sets a single bit. The 16-bit form sets one bit per half. The 8-bit form sets one bit in every byte. An encode mode goes the other way. It reports the one-based position of the highest set bit, and reserves the value zero for an operand with no bits set.

The unit has no clock and no state. An execution stage places an operand and a mode code on the inputs and takes the result and the zero flag in the same cycle. The zero flag is useful mostly in encode mode, because no decode result can be zero.

Top module: `bitmask_codec`

## Requirements
- R1: With `mode_sel` = 2'b00, `result` has exactly one bit set, at the position given by `operand[4:0]`.
- R2: With `mode_sel` = 2'b01, a 16-bit one-hot pattern selected by `operand[3:0]` appears in both `result[15:0]` and `result[31:16]`.
- R3: With `mode_sel` = 2'b10, an 8-bit one-hot pattern selected by `operand[2:0]` appears in each of the four byte lanes of `result`.
- R4: With `mode_sel` = 2'b11 and exactly one operand bit k set, `result` equals k+1. For example, bit 4 alone gives 5 and bit 31 alone gives 32.
- R5: With `mode_sel` = 2'b11 and an all-zero operand, `result` is 0.
- R6: With `mode_sel` = 2'b11 and several operand bits set, `result` is one plus the index of the most significant set bit.
- R7: In the decode modes, operand bits above the index field (bits 31:5, 31:4 and 31:3 respectively) have no effect on `result`.
- R8: `zero_flag` is 1 exactly when `result` is all zeros. It is therefore always 0 in the decode modes.
- R9: `result` and `zero_flag` follow a change of `mode_sel` or `operand` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_sel | input | 2 | 00 decode-32, 01 decode-16 replicated, 10 decode-8 replicated, 11 encode |
| operand | input | 32 | Index source for decode, mask source for encode |
| result | output | 32 | Mask or one-based bit position |
| zero_flag | output | 1 | High when result is zero |

## Verification
Every result is due in the same cycle as its stimulus, because no register sits between the inputs and the outputs. The bench changes inputs on a falling clock edge and samples one nanosecond later, before any rising edge. Each check therefore sees only the settled combinational response to the values just applied. A dedicated check changes the operand twice between two rising edges and confirms that the outputs track both changes.

// File: rtl/bitmask_codec.sv
module bitmask_codec #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        mode_sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              zero_flag
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANE_W = DATA_W / 4;
  localparam int POS_W  = IDX_W + 1;

  localparam logic [1:0] M_DEC_FULL = 2'b00;
  localparam logic [1:0] M_DEC_HALF = 2'b01;
  localparam logic [1:0] M_DEC_LANE = 2'b10;
  localparam logic [1:0] M_ENCODE   = 2'b11;

  logic [DATA_W-1:0] full_mask;
  logic [HALF_W-1:0] half_mask;
  logic [LANE_W-1:0] lane_mask;
  logic [POS_W-1:0]  top_pos;

  assign full_mask = {{(DATA_W-1){1'b0}}, 1'b1} << operand[IDX_W-1:0];
  assign half_mask = {{(HALF_W-1){1'b0}}, 1'b1} << operand[IDX_W-2:0];
  assign lane_mask = {{(LANE_W-1){1'b0}}, 1'b1} << operand[IDX_W-3:0];

  always_comb begin
    top_pos = '0;
    for (int i = 0; i < DATA_W; i++)
      if (operand[i]) top_pos = POS_W'(i + 1);
  end

  always_comb begin
    unique case (mode_sel)
      M_DEC_FULL: result = full_mask;
      M_DEC_HALF: result = {2{half_mask}};
      M_DEC_LANE: result = {4{lane_mask}};
      default:    result = {{(DATA_W-POS_W){1'b0}}, top_pos};
    endcase
  end

  assign zero_flag = ~|result;

  always_comb begin
    if (mode_sel == M_DEC_FULL)
      AST_FULL_ONEHOT: assert ($onehot(result)); // R1
    if (mode_sel == M_DEC_HALF)
      AST_HALF_MIRROR: assert (result[DATA_W-1:HALF_W] == result[HALF_W-1:0] && $onehot(result[HALF_W-1:0])); // R2
    if (mode_sel == M_DEC_LANE)
      AST_LANE_MIRROR: assert (result[31:24] == result[7:0] && result[23:16] == result[7:0] && result[15:8] == result[7:0] && $onehot(result[7:0])); // R3
    if (mode_sel == M_ENCODE)
      AST_ENC_RANGE: assert (result <= DATA_W); // R4
    if (mode_sel == M_ENCODE && result != '0)
      AST_ENC_HIGHEST: assert (operand[result - 1] && (operand >> result) == '0); // R6
    if (zero_flag)
      AST_ZERO_ONLY_EMPTY: assert (mode_sel == M_ENCODE && operand == '0); // R8
  end
endmodule

// File: tb/bitmask_codec_tb_top.sv
module bitmask_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [31:0] operand = '0;
  logic [31:0] result;
  logic        zero_flag;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bitmask_codec dut_i (
    .mode_sel (mode_sel),
    .operand  (operand),
    .result   (result),
    .zero_flag(zero_flag)
  );

  localparam int NV = 19;
  localparam logic [1:0] V_MODE [NV] = '{
    2'd0, 2'd0, 2'd0, 2'd0,
    2'd1, 2'd1, 2'd1, 2'd1,
    2'd2, 2'd2, 2'd2, 2'd2,
    2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
  localparam logic [31:0] V_OP [NV] = '{
    32'h0, 32'h1F, 32'h0A, 32'hFFFF_FFE3,
    32'h0, 32'hF, 32'h7, 32'hABCD_EF15,
    32'h0, 32'h7, 32'h5, 32'hFFFF_FFFA,
    32'h10, 32'h1, 32'h8000_0000, 32'h0, 32'h0001_0010, 32'hFFFF_FFFF, 32'h0000_0300};
  localparam logic [31:0] V_EXP [NV] = '{
    32'h1, 32'h8000_0000, 32'h400, 32'h8,
    32'h0001_0001, 32'h8000_8000, 32'h0080_0080, 32'h0020_0020,
    32'h0101_0101, 32'h8080_8080, 32'h2020_2020, 32'h0404_0404,
    32'd5, 32'd1, 32'd32, 32'd0, 32'd17, 32'd32, 32'd10};
  localparam int V_REQ [NV] = '{
    1, 1, 1, 7,   // R1 R7
    2, 2, 2, 7,   // R2 R7
    3, 3, 3, 7,   // R3 R7
    4, 4, 4, 5, 6, 6, 6}; // R4 R5 R6

  task automatic check_out(input string tag, input logic [31:0] exp_r);
    logic exp_z;
    exp_z = (exp_r == '0);
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s: result=%h expected=%h", tag, result, exp_r);
    end
    checks++;
    if (zero_flag !== exp_z) begin
      errors++;
      $display("FAIL R8 (%s): zero_flag=%b expected=%b", tag, zero_flag, exp_z);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [31:0] op);
    @(negedge clk);
    mode_sel = m;
    operand  = op;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check_out("R1 reset-state", 32'h1);

    for (int i = 0; i < NV; i++) begin
      apply(V_MODE[i], V_OP[i]);
      check_out($sformatf("R%0d vec%0d", V_REQ[i], i), V_EXP[i]);
    end

    apply(2'd3, 32'h0000_0010);
    check_out("R9 first", 32'd5);
    operand = 32'h0400_0000;
    #1;
    check_out("R9 second", 32'd27);

    apply(2'd0, 32'hFFFF_FFE0);
    check_out("R7 full-high", 32'h1);
    apply(2'd2, 32'hFFFF_FFF8);
    check_out("R7 lane-high", 32'h0101_0101);
    apply(2'd3, 32'h0000_0000);
    check_out("R5 empty", 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule